// File: doc/BRIEF.md
# Game of Life tile stepper with retained context

This block computes one Game of Life generation for a tile of cells four wide and two tall, giving eight result bits per step. Each new cell value depends on that cell and its eight surrounding cells. The engine therefore works on a window of current-generation cells that is six columns wide and four rows tall: the tile plus a one-cell border on every side.

A host sweeps across a field from left to right, one tile at a time. When the next tile sits directly to the right of the previous one, the two rightmost window columns of the previous step are still valid. The engine keeps them in an internal register, so each step needs only 16 fresh cells (four new columns). When the host jumps to a tile that is not adjacent, it clears the mode flag and the kept columns are read as dead cells. A start strobe launches a step. The result and a one-cycle valid flag appear on the next clock edge.

Top module: `life_tile_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid` is 0 and `result` is 0. Reset clears the kept columns, so an adjacent step straight after reset sees dead cells in window columns 0 and 1.
- R2: `valid` is 1 in the cycle after each cycle in which `start` is 1, and 0 in every other cycle. Back-to-back strobes give back-to-back valid cycles.
- R3: `result` changes only in a cycle that follows a `start`. Between steps it holds the last tile.
- R4: Input bit 4k+r (k in 0..3, r in 0..3) is the cell at window column k+2, window row r. Column 0 is the leftmost and row 0 is the top.
- R5: When `adjacent` is 1, window columns 0 and 1 equal window columns 4 and 5 of the previous step, which were input bits 15:8 of that step.
- R6: When `adjacent` is 0, window columns 0 and 1 are taken as dead cells, whatever the kept columns hold.
- R7: A live cell stays alive only when it has exactly 2 or 3 live neighbours.
- R8: A dead cell becomes alive only when it has exactly 3 live neighbours.
- R9: Any neighbour count of 4 to 8 kills the cell or leaves it dead.
- R10: Result bit 4*r+c is the next state of window cell (column c+1, row r+1). Window rows 0 and 3 and columns 0 and 5 act only as neighbours and never appear in the result.
- R11: The kept columns change only on a `start`. Any number of idle cycles between two adjacent steps has no effect on the second result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch one tile step this cycle |
| adjacent | input | 1 | 1: tile is the right neighbour of the previous tile; 0: jump |
| cells_in | input | 16 | Four new window columns, 4 bits each, top row in the LSB |
| result | output | 8 | Next-generation tile, bit 4*row+col |
| valid | output | 1 | Result of a step is on `result` this cycle |

## Verification
The assertions check on every cycle that `valid` follows the strobe by exactly one cycle, that `result` and the kept columns hold between steps, and that the kept columns capture the upper half of the input word on a step. They also check that a jump with an all-dead input gives an all-dead tile. The rule itself needs the bench's reference model. Column packing, survival and birth, saturation at four or more neighbours, reuse of columns across adjacent steps, and the effect of idle gaps are only visible through specific patterns and sequences, so those are covered by the bench.

// File: rtl/life_tile_pkg.sv
package life_tile_pkg;

  // Neighbour count of eight cells, saturating at four ("too many").
  function automatic logic [2:0] sat_count8(input logic [7:0] nb);
    logic [3:0] total;
    total = 4'd0;
    for (int i = 0; i < 8; i++) begin
      total = total + {3'd0, nb[i]};
    end
    if (total >= 4'd4) return 3'd4;
    return total[2:0];
  endfunction

  // Next state from own state and a saturated neighbour count.
  function automatic logic life_rule(input logic self_alive, input logic [2:0] cnt);
    logic birth;
    logic survive;
    birth   = (cnt == 3'd3);
    survive = self_alive && (cnt == 3'd2);
    return birth || survive;
  endfunction

endpackage

// File: rtl/life_ctx_store.sv
module life_ctx_store #(
  parameter int CTX_H     = 4,
  parameter int KEEP_COLS = 2,
  parameter int NEW_COLS  = 4,
  localparam int KEEP_BITS = KEEP_COLS * CTX_H,
  localparam int NEW_BITS  = NEW_COLS * CTX_H,
  localparam int WIN_BITS  = KEEP_BITS + NEW_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 adjacent,
  input  logic [NEW_BITS-1:0]  new_cells,
  output logic [WIN_BITS-1:0]  window,
  output logic [KEEP_BITS-1:0] keep_q
);

  logic [KEEP_BITS-1:0] left_cols;
  logic [KEEP_BITS-1:0] keep_next;

  // Jump to a non-adjacent tile: retained columns read as dead cells.
  always_comb begin
    if (adjacent) left_cols = keep_q;
    else          left_cols = '0;
  end

  assign window    = {new_cells, left_cols};
  assign keep_next = window[WIN_BITS-1 -: KEEP_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q <= '0;
    end else if (load) begin
      keep_q <= keep_next;
    end
  end

endmodule

// File: rtl/life_cell_rule.sv
module life_cell_rule
  import life_tile_pkg::*;
(
  input  logic       self_alive,
  input  logic [7:0] nb,
  output logic [2:0] nb_count,
  output logic       next_alive
);

  assign nb_count   = sat_count8(nb);
  assign next_alive = life_rule(self_alive, nb_count);

endmodule

// File: rtl/life_tile_array.sv
module life_tile_array #(
  parameter int TILE_W = 4,
  parameter int TILE_H = 2,
  localparam int CTX_W    = TILE_W + 2,
  localparam int CTX_H    = TILE_H + 2,
  localparam int WIN_BITS = CTX_W * CTX_H,
  localparam int OUT_BITS = TILE_W * TILE_H
) (
  input  logic [WIN_BITS-1:0]   window,
  output logic [OUT_BITS-1:0]   next_tile,
  output logic [3*OUT_BITS-1:0] counts
);

  function automatic int win_idx(input int col, input int row);
    return col * CTX_H + row;
  endfunction

  for (genvar r = 0; r < TILE_H; r++) begin : g_row
    for (genvar c = 0; c < TILE_W; c++) begin : g_col
      localparam int CX = c + 1;
      localparam int RY = r + 1;
      localparam int OB = r * TILE_W + c;
      logic [7:0] nb;
      logic [2:0] cnt;
      logic       nxt;

      assign nb = {window[win_idx(CX-1, RY-1)], window[win_idx(CX, RY-1)],
                   window[win_idx(CX+1, RY-1)], window[win_idx(CX-1, RY)],
                   window[win_idx(CX+1, RY)],   window[win_idx(CX-1, RY+1)],
                   window[win_idx(CX, RY+1)],   window[win_idx(CX+1, RY+1)]};

      life_cell_rule u_cell (
        .self_alive (window[win_idx(CX, RY)]),
        .nb         (nb),
        .nb_count   (cnt),
        .next_alive (nxt)
      );

      assign next_tile[OB]          = nxt;
      assign counts[3*OB +: 3]      = cnt;
    end
  end

endmodule

// File: rtl/life_tile_engine.sv
module life_tile_engine #(
  parameter int TILE_W = 4,
  parameter int TILE_H = 2,
  localparam int CTX_H     = TILE_H + 2,
  localparam int CTX_W     = TILE_W + 2,
  localparam int KEEP_COLS = 2,
  localparam int IN_BITS   = TILE_W * CTX_H,
  localparam int KEEP_BITS = KEEP_COLS * CTX_H,
  localparam int WIN_BITS  = CTX_W * CTX_H,
  localparam int OUT_BITS  = TILE_W * TILE_H
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                adjacent,
  input  logic [IN_BITS-1:0]  cells_in,
  output logic [OUT_BITS-1:0] result,
  output logic                valid
);

  logic [WIN_BITS-1:0]   window;
  logic [KEEP_BITS-1:0]  keep_q;
  logic [OUT_BITS-1:0]   tile_next;
  logic [3*OUT_BITS-1:0] nb_counts;
  logic                  step_fire;

  assign step_fire = start;

  life_ctx_store #(
    .CTX_H     (CTX_H),
    .KEEP_COLS (KEEP_COLS),
    .NEW_COLS  (TILE_W)
  ) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (step_fire),
    .adjacent  (adjacent),
    .new_cells (cells_in),
    .window    (window),
    .keep_q    (keep_q)
  );

  life_tile_array #(
    .TILE_W (TILE_W),
    .TILE_H (TILE_H)
  ) u_array (
    .window    (window),
    .next_tile (tile_next),
    .counts    (nb_counts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= step_fire;
      if (step_fire) result <= tile_next;
    end
  end

endmodule

// File: rtl/life_tile_engine_chk.sv
module life_tile_engine_chk #(
  parameter int IN_BITS   = 16,
  parameter int KEEP_BITS = 8,
  parameter int OUT_BITS  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 adjacent,
  input logic [IN_BITS-1:0]   cells_in,
  input logic [OUT_BITS-1:0]  result,
  input logic                 valid,
  input logic [KEEP_BITS-1:0] keep_q,
  input logic [3*OUT_BITS-1:0] nb_counts
);

  a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);

  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));

  a_r5_keep_capture: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> keep_q == $past(cells_in[IN_BITS-1 -: KEEP_BITS]));

  a_r11_keep_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(keep_q));

  a_r6_jump_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !adjacent && cells_in == '0) |=> result == '0);

  // R9: no saturated count ever exceeds four
  for (genvar i = 0; i < OUT_BITS; i++) begin : g_cnt
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      nb_counts[3*i +: 3] <= 3'd4);
  end

endmodule

bind life_tile_engine life_tile_engine_chk #(
  .IN_BITS   (IN_BITS),
  .KEEP_BITS (KEEP_BITS),
  .OUT_BITS  (OUT_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .adjacent  (adjacent),
  .cells_in  (cells_in),
  .result    (result),
  .valid     (valid),
  .keep_q    (keep_q),
  .nb_counts (nb_counts)
);

// File: tb/life_tile_engine_test.sv
module life_tile_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        adjacent = 1'b0;
  logic [15:0] cells_in = '0;
  logic [7:0]  result;
  logic        valid;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_keep = '0;
  logic [7:0] ref_result = '0;
  logic       ref_valid = 1'b0;

  always #10 clk = ~clk;

  life_tile_engine uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .adjacent (adjacent),
    .cells_in (cells_in),
    .result   (result),
    .valid    (valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model: plain integer grid, full unsaturated count.
  function automatic logic [7:0] model_tile(input logic [7:0] keep, input bit adj,
                                            input logic [15:0] cells);
    int grid [6][4];
    logic [7:0] out;
    for (int col = 0; col < 6; col++)
      for (int row = 0; row < 4; row++) begin
        if (col < 2) grid[col][row] = adj ? int'(keep[col*4+row]) : 0;
        else         grid[col][row] = int'(cells[(col-2)*4+row]);
      end
    out = '0;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++) begin
        int n;
        int me;
        me = grid[c+1][r+1];
        n = 0;
        for (int dx = -1; dx <= 1; dx++)
          for (int dy = -1; dy <= 1; dy++)
            if (dx != 0 || dy != 0) n += grid[c+1+dx][r+1+dy];
        out[r*4+c] = (n == 3) || (me == 1 && n == 2);
      end
    return out;
  endfunction

  // One clock: drive at the falling edge, compare after the rising edge.
  task automatic cycle(input bit s, input bit adj, input logic [15:0] cells, input string tag);
    start = s;
    adjacent = adj;
    cells_in = cells;
    @(posedge clk);
    #2;
    if (s) begin
      ref_result = model_tile(ref_keep, adj, cells);
      ref_keep = cells[15:8];
    end
    ref_valid = s;
    check(valid === ref_valid, {tag, " R2 valid"}, int'(valid), int'(ref_valid));
    check(result === ref_result, s ? {tag, " result"} : {tag, " R3 hold"},
          int'(result), int'(ref_result));
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid === 1'b0, "R1 valid in reset", int'(valid), 0);
    check(result === 8'h00, "R1 result in reset", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid === 1'b0 && result === 8'h00, "R1 after reset", int'(result), 0);

    // R1: adjacent step right after reset sees dead kept columns
    cycle(1, 1, 16'h1111, "R1 kept clear");
    check(result === 8'h0C, "R1 R10 row0 only as neighbour", int'(result), 8'h0C);

    // R4 R7 R8: horizontal blinker becomes vertical
    cycle(1, 0, 16'h0222, "R4 blinker");
    check(result === 8'h44, "R4 R7 R8 blinker", int'(result), 8'h44);

    // R9 R6: four full columns on a jump
    cycle(1, 0, 16'hFFFF, "R9 full");
    check(result === 8'h11, "R9 R6 saturation", int'(result), 8'h11);

    // R5: adjacent step reuses full kept columns
    cycle(1, 1, 16'h0000, "R5 reuse");
    check(result === 8'h22, "R5 adjacent reuse", int'(result), 8'h22);

    // R6: kept ones ignored on a jump
    cycle(1, 0, 16'hFFFF, "R6 load");
    cycle(1, 0, 16'h0000, "R6 jump");
    check(result === 8'h00, "R6 jump ignores kept", int'(result), 8'h00);

    // R11 R3: idle gap between adjacent steps
    cycle(1, 0, 16'hFFFF, "R11 load");
    for (int i = 0; i < 5; i++) cycle(0, i[0], 16'hA5A5, "R11 idle");
    cycle(1, 1, 16'h0000, "R11 after gap");
    check(result === 8'h22, "R11 kept through idle", int'(result), 8'h22);

    // R2: back-to-back strobes
    cycle(1, 1, 16'h3C3C, "R2 burst");
    cycle(1, 1, 16'h0F0F, "R2 burst");
    cycle(1, 0, 16'h6666, "R2 burst");

    // R7 R8 R9 R10: random sweep with idle gaps
    for (int i = 0; i < 300; i++) begin
      logic [15:0] pat;
      pat = 16'($urandom);
      cycle(($urandom % 4) != 0, ($urandom % 3) != 0, pat, "R7 R8 R9 R10 random");
    end

    // R1: reset in mid-run clears kept columns
    cycle(1, 0, 16'hFFFF, "R1 preload");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    ref_keep = '0;
    ref_result = '0;
    cycle(1, 1, 16'h0000, "R1 reset clears");
    check(result === 8'h00, "R1 kept cleared by reset", int'(result), 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule